// File: doc/BRIEF.md
# Proximity Card Activation Controller

This block is the card-side control logic that brings a contactless card from power-up to the selected state. It receives frames that have already been decoded into bytes. Each frame has a command byte, a second byte that gives the frame's kind, up to five payload bytes and a one-cycle strobe. The block answers with response frames and shows its current state. The identifier (4, 7 or 10 bytes) and its length are parameters.

After the RF field appears, the card waits in a sleep state. A request or wake-up frame makes it answer with a two-byte capability word and become ready. The reader then runs one, two or three cascade rounds, depending on identifier length. In each round it first asks for the identifier part of that round, then selects it by sending that part back. After the last round the card is active. A halt frame parks the card in a second sleep state, and only the wake-up frame leaves that state. Removing the field clears everything.

State codes on `card_state`: 0 powered-off/reset, 1 idle, 2 ready, 3 active, 4 halted. Byte 0 of any frame field is bits [7:0], byte 1 is bits [15:8], and so on.

Top module: `card_activation_fsm`

## Requirements
- R1: While the field is present, the reset state (code 0) moves to idle (code 1) on the next clock. A frame that arrives in that same cycle is dropped without response.
- R2: In idle, only command 0x26 (request) or 0x52 (wake-up) is answered. Either one gives the capability word and moves the card to ready. Every other command leaves the card idle and gives no response.
- R3: In halted, command 0x26 is ignored and gives no response. Command 0x52 gives the capability word and moves the card to ready. All other commands are also ignored.
- R4: The capability word is 2 bytes long. In byte 0, bits [7:6] are 00, 01 or 10 for a 4, 7 or 10 byte identifier, bit 0 is 1 and all other bits are 0. Byte 1 is 0x00.
- R5: In ready at cascade round L (L = 0, 1, 2), command 0x93+2L with second byte 0x20 gives a 5-byte reply. In a non-final round the reply is 0x88 followed by the next three identifier bytes. In the final round the reply is the last four identifier bytes. Byte 4 is the XOR of bytes 0 to 3.
- R6: In ready, command 0x93+2L with second byte 0x70 and a payload equal to that round's 5-byte reply gives a 1-byte select acknowledge. In a non-final round the acknowledge is 0x04 and the round advances. In the final round it is 0x00 (bit 2 clear) and the card becomes active.
- R7: In ready or active, any other frame gives no response and puts the card back to sleep. This includes a select with mismatching payload and a command code for the wrong round. The card goes to halted if the wake-up from halted started this activation, and to idle otherwise.
- R8: In active, command 0x50 with second byte 0x00 moves the card to halted with no response.
- R9: When the field is absent at a clock edge, the card is in the reset state after that edge and gives no response, even if a frame arrives in the same cycle. When the field returns, the card starts again from idle.
- R10: A response is a one-cycle pulse on `rsp_valid` on the clock after the frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_on | input | 1 | RF field present |
| frm_valid | input | 1 | One-cycle strobe for a decoded frame |
| frm_cmd | input | 8 | Command byte |
| frm_arg | input | 8 | Second byte of the frame |
| frm_data | input | 40 | Payload bytes 0..4 |
| rsp_valid | output | 1 | Response frame strobe |
| rsp_len | output | 3 | Response length in bytes |
| rsp_data | output | 40 | Response bytes, byte 0 in bits [7:0] |
| card_state | output | 3 | Current state code |

## Verification
A frame strobe and a loss of field can fall in the same cycle. So can a frame strobe and the automatic step from reset to idle. The bench provokes the first case by dropping `field_on` in the same cycle as an anticollision frame. It expects no response and the reset state. It provokes the second case by raising the field again together with a request frame. It expects idle with no reply, and then a normal answer to the next request, which shows that the halted history was wiped.

// File: rtl/card_activation_fsm.sv
module card_activation_fsm #(
  parameter int          UID_BYTES = 7,
  parameter logic [79:0] UID       = 80'hF1E2D3C4B5A697887766
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        field_on,
  input  logic        frm_valid,
  input  logic [7:0]  frm_cmd,
  input  logic [7:0]  frm_arg,
  input  logic [39:0] frm_data,
  output logic        rsp_valid,
  output logic [2:0]  rsp_len,
  output logic [39:0] rsp_data,
  output logic [2:0]  card_state
);
  localparam int           LEVELS    = (UID_BYTES == 4) ? 1 : (UID_BYTES == 7) ? 2 : 3;
  localparam logic [1:0]   SIZE_CODE = 2'(LEVELS - 1);
  localparam logic [103:0] UIDP      = {24'h0, UID};
  localparam logic [7:0]   C_REQ = 8'h26, C_WAKE = 8'h52, C_HALT = 8'h50, CASCADE = 8'h88;
  localparam logic [7:0]   K_ANTI = 8'h20, K_SEL = 8'h70;

  typedef enum logic [2:0] {S_POR = 3'd0, S_IDLE = 3'd1, S_READY = 3'd2, S_ACTIVE = 3'd3, S_HALT = 3'd4} st_t;

  st_t        st;
  logic       woke;
  logic [1:0] lvl;
  logic       last_lvl;
  logic [31:0] lvl_bytes;
  logic [7:0]  bcc, sel_code;
  logic        is_anti, is_sel, sel_ok;
  st_t         fall;

  assign last_lvl  = (int'(lvl) == LEVELS - 1);
  assign lvl_bytes = last_lvl ? UIDP[int'(lvl)*24 +: 32] : {UIDP[int'(lvl)*24 +: 24], CASCADE};
  assign bcc       = lvl_bytes[7:0] ^ lvl_bytes[15:8] ^ lvl_bytes[23:16] ^ lvl_bytes[31:24];
  assign sel_code  = 8'h93 + {5'd0, lvl, 1'b0};
  assign is_anti   = (frm_cmd == sel_code) && (frm_arg == K_ANTI);
  assign is_sel    = (frm_cmd == sel_code) && (frm_arg == K_SEL);
  assign sel_ok    = (frm_data == {bcc, lvl_bytes});
  assign fall      = woke ? S_HALT : S_IDLE;
  assign card_state = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_POR;
      woke      <= 1'b0;
      lvl       <= 2'd0;
      rsp_valid <= 1'b0;
      rsp_len   <= 3'd0;
      rsp_data  <= 40'd0;
    end else begin
      rsp_valid <= 1'b0;
      if (!field_on) begin
        st   <= S_POR;
        woke <= 1'b0;
        lvl  <= 2'd0;
      end else begin
        case (st)
          S_POR: st <= S_IDLE;
          S_IDLE, S_HALT:
            if (frm_valid && (frm_cmd == C_WAKE || (frm_cmd == C_REQ && st == S_IDLE))) begin
              st        <= S_READY;
              woke      <= (st == S_HALT);
              lvl       <= 2'd0;
              rsp_valid <= 1'b1;
              rsp_len   <= 3'd2;
              rsp_data  <= {32'd0, SIZE_CODE, 6'b000001};
            end
          S_READY:
            if (frm_valid) begin
              if (is_anti) begin
                rsp_valid <= 1'b1;
                rsp_len   <= 3'd5;
                rsp_data  <= {bcc, lvl_bytes};
              end else if (is_sel && sel_ok) begin
                rsp_valid <= 1'b1;
                rsp_len   <= 3'd1;
                rsp_data  <= {32'd0, 5'd0, ~last_lvl, 2'b00};
                if (last_lvl) st <= S_ACTIVE;
                else          lvl <= lvl + 2'd1;
              end else begin
                st <= fall;
              end
            end
          S_ACTIVE:
            if (frm_valid) begin
              if (frm_cmd == C_HALT && frm_arg == 8'h00) st <= S_HALT;
              else                                       st <= fall;
            end
          default: st <= S_POR;
        endcase
      end
    end
  end

  p_por_to_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POR && field_on) |=> (st == S_IDLE && !rsp_valid));

  p_halt_ignores_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HALT && field_on && frm_valid && frm_cmd == C_REQ) |=> (st == S_HALT && !rsp_valid));

  p_wake_reply_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && st == S_READY && $past(st) != S_READY) |-> (rsp_len == 3'd2 && rsp_data[0]));

  p_check_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_len == 3'd5) |->
      (rsp_data[39:32] == (rsp_data[7:0] ^ rsp_data[15:8] ^ rsp_data[23:16] ^ rsp_data[31:24])));

  p_final_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && st == S_ACTIVE) |-> (rsp_len == 3'd1 && !rsp_data[2]));

  p_partial_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && st == S_READY && rsp_len == 3'd1) |-> rsp_data[2]);

  p_halt_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACTIVE && field_on && frm_valid && frm_cmd == C_HALT && frm_arg == 8'h00)
      |=> (st == S_HALT && !rsp_valid));

  p_field_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !field_on |=> (st == S_POR && !rsp_valid));

  p_reply_follows_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(frm_valid));
endmodule

// File: tb/test_card_activation_fsm.sv
`timescale 1ns/1ps
module test_card_activation_fsm;
  localparam logic [79:0] UIDV = 80'hF1E2D3C4B5A697887766;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        fld [3];
  logic        fv  [3];
  logic [7:0]  fc  [3];
  logic [7:0]  fa  [3];
  logic [39:0] fd  [3];
  logic        rv  [3];
  logic [2:0]  rl  [3];
  logic [39:0] rd  [3];
  logic [2:0]  so  [3];

  for (genvar gk = 0; gk < 3; gk++) begin : g_dut
    card_activation_fsm #(.UID_BYTES(4 + 3 * gk), .UID(UIDV)) i_card_activation_fsm (
      .clk(clk), .rst_n(rst_n), .field_on(fld[gk]), .frm_valid(fv[gk]),
      .frm_cmd(fc[gk]), .frm_arg(fa[gk]), .frm_data(fd[gk]),
      .rsp_valid(rv[gk]), .rsp_len(rl[gk]), .rsp_data(rd[gk]), .card_state(so[gk]));
  end

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [39:0] act, input logic [39:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input int k, input string req, input bit v,
                            input logic [2:0] len, input logic [39:0] data, input logic [2:0] st);
    chk(rv[k] == v, req, "rsp_valid", 40'(rv[k]), 40'(v));
    if (v) begin
      chk(rl[k] == len, req, "rsp_len", 40'(rl[k]), 40'(len));
      chk(rd[k] == data, req, "rsp_data", rd[k], data);
    end
    chk(so[k] == st, req, "state", 40'(so[k]), 40'(st));
  endtask

  task automatic send(input int k, input logic [7:0] c, input logic [7:0] a, input logic [39:0] d);
    @(negedge clk);
    fc[k] = c; fa[k] = a; fd[k] = d; fv[k] = 1'b1;
    @(negedge clk);
    fv[k] = 1'b0;
  endtask

  function automatic logic [31:0] level_bytes(input int n, input int L);
    int levels = (n - 1) / 3;
    logic [31:0] r;
    if (L < levels - 1)
      r = {UIDV[8*(3*L+2) +: 8], UIDV[8*(3*L+1) +: 8], UIDV[8*(3*L) +: 8], 8'h88};
    else
      r = {UIDV[8*(3*L+3) +: 8], UIDV[8*(3*L+2) +: 8], UIDV[8*(3*L+1) +: 8], UIDV[8*(3*L) +: 8]};
    return r;
  endfunction

  function automatic logic [39:0] level_frame(input int n, input int L);
    logic [31:0] b = level_bytes(n, L);
    return {b[7:0] ^ b[15:8] ^ b[23:16] ^ b[31:24], b};
  endfunction

  function automatic logic [39:0] atqa(input int k);
    return {32'd0, 2'(k), 6'b000001};
  endfunction

  task automatic activate(input int k, input logic [7:0] wake);
    int levels = k + 1;
    send(k, wake, 8'h00, 40'd0);
    expect_out(k, "R4", 1'b1, 3'd2, atqa(k), 3'd2);
    for (int L = 0; L < levels; L++) begin
      send(k, 8'h93 + 8'(2 * L), 8'h20, 40'd0);
      expect_out(k, "R5", 1'b1, 3'd5, level_frame(4 + 3 * k, L), 3'd2);
      send(k, 8'h93 + 8'(2 * L), 8'h70, level_frame(4 + 3 * k, L));
      if (L < levels - 1) expect_out(k, "R6", 1'b1, 3'd1, 40'h04, 3'd2);
      else                expect_out(k, "R6", 1'b1, 3'd1, 40'h00, 3'd3);
      @(negedge clk);
      chk(rv[k] == 1'b0, "R10", "pulse width", 40'(rv[k]), 40'd0);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      fld[k] = 1'b1; fv[k] = 1'b0; fc[k] = 8'h00; fa[k] = 8'h00; fd[k] = 40'd0;
    end
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++) chk(so[k] == 3'd0 && rv[k] == 1'b0, "R1", "reset state", 40'(so[k]), 40'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 3; k++) chk(so[k] == 3'd1, "R1", "idle after reset", 40'(so[k]), 40'd1);

    for (int k = 0; k < 3; k++) begin
      // R2: sweep every command code in idle
      for (int c = 0; c < 256; c++) begin
        send(k, 8'(c), 8'h00, 40'd0);
        if (c == 'h26 || c == 'h52) begin
          expect_out(k, "R2", 1'b1, 3'd2, atqa(k), 3'd2);
          send(k, 8'h00, 8'h00, 40'd0);
          expect_out(k, "R7", 1'b0, 3'd0, 40'd0, 3'd1);
        end else begin
          expect_out(k, "R2", 1'b0, 3'd0, 40'd0, 3'd1);
        end
      end

      activate(k, 8'h26);
      send(k, 8'h50, 8'h00, 40'd0);
      expect_out(k, "R8", 1'b0, 3'd0, 40'd0, 3'd4);

      // R3: sweep every command code in halted
      for (int c = 0; c < 256; c++) begin
        send(k, 8'(c), 8'h00, 40'd0);
        if (c == 'h52) begin
          expect_out(k, "R3", 1'b1, 3'd2, atqa(k), 3'd2);
          send(k, 8'h00, 8'h00, 40'd0);
          expect_out(k, "R7", 1'b0, 3'd0, 40'd0, 3'd4);
        end else begin
          expect_out(k, "R3", 1'b0, 3'd0, 40'd0, 3'd4);
        end
      end

      // R7: mismatched select after wake from halt
      send(k, 8'h52, 8'h00, 40'd0);
      send(k, 8'h93, 8'h20, 40'd0);
      send(k, 8'h93, 8'h70, level_frame(4 + 3 * k, 0) ^ 40'h0000000100);
      expect_out(k, "R7", 1'b0, 3'd0, 40'd0, 3'd4);
      // R7: select with the code of the wrong round
      send(k, 8'h52, 8'h00, 40'd0);
      send(k, 8'h95, 8'h70, level_frame(4 + 3 * k, 0));
      expect_out(k, "R7", 1'b0, 3'd0, 40'd0, 3'd4);

      // R9: field loss together with a frame
      send(k, 8'h52, 8'h00, 40'd0);
      @(negedge clk);
      fld[k] = 1'b0; fc[k] = 8'h93; fa[k] = 8'h20; fv[k] = 1'b1;
      @(negedge clk);
      expect_out(k, "R9", 1'b0, 3'd0, 40'd0, 3'd0);
      // R1: field returns together with a request frame
      fld[k] = 1'b1; fc[k] = 8'h26; fa[k] = 8'h00;
      @(negedge clk);
      fv[k] = 1'b0;
      expect_out(k, "R1", 1'b0, 3'd0, 40'd0, 3'd1);
      send(k, 8'h26, 8'h00, 40'd0);
      expect_out(k, "R9", 1'b1, 3'd2, atqa(k), 3'd2);
      // R7: mismatch from idle-origin returns to idle
      send(k, 8'h93, 8'h70, ~level_frame(4 + 3 * k, 0));
      expect_out(k, "R7", 1'b0, 3'd0, 40'd0, 3'd1);

      // R9: field loss in active restarts from idle
      activate(k, 8'h26);
      @(negedge clk);
      fld[k] = 1'b0;
      @(negedge clk);
      expect_out(k, "R9", 1'b0, 3'd0, 40'd0, 3'd0);
      fld[k] = 1'b1;
      @(negedge clk);
      chk(so[k] == 3'd1, "R9", "idle after field return", 40'(so[k]), 40'd1);
      // R7: unexpected frame in active falls back to idle
      activate(k, 8'h26);
      send(k, 8'h30, 8'h04, 40'd0);
      expect_out(k, "R7", 1'b0, 3'd0, 40'd0, 3'd1);
    end

    report();
    $finish;
  end
endmodule